// File: doc/BRIEF.md
# Real-Time Clock with Calendar-Day Alarm

This block is a memory-mapped real-time clock. It counts seconds, minutes, hours and a binary day number, and it advances by one second each time a one-cycle tick pulse arrives from outside. Logic elsewhere on the chip produces that pulse from the slow reference clock. Software can read and write every time field through a small 32-bit register port. It sets an alarm as a day number plus hours, minutes and seconds, and it steers events to a level interrupt line through a status register and an enable mask. Status bits are cleared by writing 1 to them.

Hours and minutes share one register. The hour sits in the upper byte and the minute in the lower byte. The day counter is 9 or 16 bits wide, set by a parameter. An alarm is raised only when the day, hour, minute and second all match on the same tick. A run bit in the control register freezes the counters while software loads a new time.

Registers sit on 32-bit word offsets: hour/minute 0x00, seconds 0x04, alarm hour/minute 0x08, alarm seconds 0x0C, control 0x10, status 0x14, enable 0x18, day 0x20 and alarm day 0x24. The offset 0x1C and every offset not listed are reserved.

Top module: `rtc_alarm_core`

## Requirements
- R1: After a synchronous active-low reset, every register reads as zero and `irq_out` is low.
- R2: The hour/minute register keeps the hour in bits 12:8 and the minute in bits 5:0. The seconds register keeps bits 5:0. The day register keeps the low DAY_W bits. Every other bit of these registers reads as zero.
- R3: On a tick while running, the seconds count up. A field at or above its last value (59 for seconds and minutes, 23 for hours) returns to 0 and carries into the next field, and an hour carry increments the day.
- R4: The day counter wraps from 2^DAY_W-1 to 0.
- R5: Control bit 7 is the run bit, and only that bit reads back (value 0x80 or 0). While the run bit is clear, a tick changes neither the time nor the status register.
- R6: A bus write to the hour/minute, seconds or day register in the same cycle as a tick loads the written value. That tick does not change any time field.
- R7: Status bit 4 sets on every tick that arrives while running.
- R8: Status bit 2 sets on a running tick whose resulting day, hour, minute and second all equal the alarm registers. A match of only some fields does not set it, and neither does a bus write that makes the time equal the alarm.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A set event in the same cycle as a clearing write wins.
- R10: The enable register holds 16 bits and reads back bits 15:0. `irq_out` is high exactly when some status bit and its enable bit are both 1.
- R11: Reads from offset 0x1C and from any undefined offset return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| tick_in | input | 1 | One-cycle pulse, once per second |
| irq_out | output | 1 | Level interrupt request |

## Verification
Each time register is read back after every tick of a long sweep. The sweep crosses minute, hour and day boundaries and the day counter's wrap, so a wrong carry or a missed wrap appears in a register value within one tick of the fault. A wrong status or enable state appears at `irq_out` and in the status read in the cycle after the event. Write-versus-tick collisions, partial alarm matches and set-versus-clear collisions are each driven on their exact cycle, so a priority error appears on the very next read.

// File: rtl/rtc_pkg.sv
// Shared constants and types for the real-time clock.
// Assumes 32-bit word-aligned registers, decoded on address bits 5:2.
package rtc_pkg;
    localparam int SEC_W = 6;
    localparam int MIN_W = 6;
    localparam int HR_W  = 5;
    localparam int HR_LSB = 8;

    // Word index = byte offset / 4
    localparam logic [3:0] IX_HM    = 4'h0;
    localparam logic [3:0] IX_SEC   = 4'h1;
    localparam logic [3:0] IX_AHM   = 4'h2;
    localparam logic [3:0] IX_ASEC  = 4'h3;
    localparam logic [3:0] IX_CTRL  = 4'h4;
    localparam logic [3:0] IX_STAT  = 4'h5;
    localparam logic [3:0] IX_IEN   = 4'h6;
    localparam logic [3:0] IX_DAY   = 4'h8;
    localparam logic [3:0] IX_ADAY  = 4'h9;

    localparam int ST_ALARM = 2;
    localparam int ST_ONEHZ = 4;
    localparam int CTRL_RUN = 7;

    typedef struct packed {
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] mn;
        logic [SEC_W-1:0] sc;
    } hms_t;
endpackage

// File: rtl/rtc_timekeeper.sv
// Time-of-day and day counters.
// Assumes the tick is a one-cycle pulse; a field write in the tick cycle
// wins and the increment for that tick is dropped.
module rtc_timekeeper
    import rtc_pkg::*;
#(
    parameter int DAY_W    = 16,
    parameter int SEC_LAST = 59,
    parameter int MIN_LAST = 59,
    parameter int HR_LAST  = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             wr_hm,
    input  logic             wr_sec,
    input  logic             wr_day,
    input  logic [31:0]      wdata,
    output hms_t             hms_q,
    output logic [DAY_W-1:0] day_q,
    output hms_t             hms_nxt,
    output logic [DAY_W-1:0] day_nxt,
    output logic             step
);
    hms_t             inc;
    logic [DAY_W-1:0] dinc;
    logic             wr_any;

    assign step   = tick & run;
    assign wr_any = wr_hm | wr_sec | wr_day;

    // One-second increment with cascaded carries
    always_comb begin
        inc  = hms_q;
        dinc = day_q;
        if (hms_q.sc >= SEC_W'(SEC_LAST)) begin
            inc.sc = '0;
            if (hms_q.mn >= MIN_W'(MIN_LAST)) begin
                inc.mn = '0;
                if (hms_q.hr >= HR_W'(HR_LAST)) begin
                    inc.hr = '0;
                    dinc   = day_q + 1'b1;
                end else begin
                    inc.hr = hms_q.hr + 1'b1;
                end
            end else begin
                inc.mn = hms_q.mn + 1'b1;
            end
        end else begin
            inc.sc = hms_q.sc + 1'b1;
        end
    end

    // Next time: bus write first, then the tick increment
    always_comb begin
        hms_nxt = hms_q;
        day_nxt = day_q;
        if (wr_any) begin
            if (wr_hm) begin
                hms_nxt.hr = wdata[HR_LSB +: HR_W];
                hms_nxt.mn = wdata[0 +: MIN_W];
            end
            if (wr_sec) hms_nxt.sc = wdata[0 +: SEC_W];
            if (wr_day) day_nxt    = wdata[0 +: DAY_W];
        end else if (step) begin
            hms_nxt = inc;
            day_nxt = dinc;
        end
    end

    // Time registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hms_q <= '0;
            day_q <= '0;
        end else begin
            hms_q <= hms_nxt;
            day_q <= day_nxt;
        end
    end
endmodule

// File: rtl/rtc_alarm_unit.sv
// Alarm registers and the full-field comparator.
// Assumes the comparison uses the time value being loaded on a running tick.
module rtc_alarm_unit
    import rtc_pkg::*;
#(
    parameter int DAY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ahm,
    input  logic             wr_asec,
    input  logic             wr_aday,
    input  logic [31:0]      wdata,
    input  logic             step,
    input  hms_t             hms_nxt,
    input  logic [DAY_W-1:0] day_nxt,
    output hms_t             al_hms_q,
    output logic [DAY_W-1:0] al_day_q,
    output logic             hit
);
    // Alarm storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            al_hms_q <= '0;
            al_day_q <= '0;
        end else begin
            if (wr_ahm) begin
                al_hms_q.hr <= wdata[HR_LSB +: HR_W];
                al_hms_q.mn <= wdata[0 +: MIN_W];
            end
            if (wr_asec) al_hms_q.sc <= wdata[0 +: SEC_W];
            if (wr_aday) al_day_q    <= wdata[0 +: DAY_W];
        end
    end

    // All four fields must match on a running tick
    assign hit = step && (hms_nxt == al_hms_q) && (day_nxt == al_day_q);
endmodule

// File: rtl/rtc_irq_ctrl.sv
// Interrupt status (write-1-to-clear), enable mask and level request.
// Assumes a set event outranks a clearing write in the same cycle.
module rtc_irq_ctrl #(
    parameter int ST_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stat,
    input  logic            wr_ien,
    input  logic [ST_W-1:0] wdata,
    input  logic [ST_W-1:0] set_vec,
    output logic [ST_W-1:0] stat_q,
    output logic [ST_W-1:0] ien_q,
    output logic            irq
);
    // Per-bit sticky status
    for (genvar i = 0; i < ST_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) stat_q[i] <= 1'b0;
            else        stat_q[i] <= set_vec[i] | (stat_q[i] & ~(wr_stat & wdata[i]));
        end
    end

    // Enable mask
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (wr_ien) ien_q <= wdata;
    end

    assign irq = |(stat_q & ien_q);
endmodule

// File: rtl/rtc_alarm_core.sv
// Top of the real-time clock: register decode, run control and read mux.
// Assumes single-cycle bus writes and a combinational read path.
module rtc_alarm_core
    import rtc_pkg::*;
#(
    parameter int DAY_W  = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_in,
    output logic              irq_out
);
    localparam int ST_W = 16;

    logic             in_map, wr;
    logic [3:0]       idx;
    logic             run_q, wr_time, wr_hm, wr_sec, wr_day, step, hit;
    hms_t             hms_q, hms_nxt, al_hms_q;
    logic [DAY_W-1:0] day_q, day_nxt, al_day_q;
    logic [ST_W-1:0]  stat_q, ien_q, set_vec;

    // Address decode
    assign in_map  = (bus_addr >> 6) == '0;
    assign idx     = bus_addr[5:2];
    assign wr      = bus_sel & bus_wr & in_map;
    assign wr_hm   = wr && idx == IX_HM;
    assign wr_sec  = wr && idx == IX_SEC;
    assign wr_day  = wr && idx == IX_DAY;
    assign wr_time = wr_hm | wr_sec | wr_day;

    // Run bit of the control register
    always_ff @(posedge clk) begin
        if (!rst_n)                    run_q <= 1'b0;
        else if (wr && idx == IX_CTRL) run_q <= bus_wdata[CTRL_RUN];
    end

    rtc_timekeeper #(.DAY_W(DAY_W)) u_time (
        .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick_in),
        .wr_hm(wr_hm), .wr_sec(wr_sec), .wr_day(wr_day), .wdata(bus_wdata),
        .hms_q(hms_q), .day_q(day_q), .hms_nxt(hms_nxt), .day_nxt(day_nxt),
        .step(step)
    );

    rtc_alarm_unit #(.DAY_W(DAY_W)) u_alarm (
        .clk(clk), .rst_n(rst_n),
        .wr_ahm(wr && idx == IX_AHM), .wr_asec(wr && idx == IX_ASEC),
        .wr_aday(wr && idx == IX_ADAY), .wdata(bus_wdata),
        .step(step), .hms_nxt(hms_nxt), .day_nxt(day_nxt),
        .al_hms_q(al_hms_q), .al_day_q(al_day_q), .hit(hit)
    );

    // Status event sources
    always_comb begin
        set_vec           = '0;
        set_vec[ST_ALARM] = hit;
        set_vec[ST_ONEHZ] = step;
    end

    rtc_irq_ctrl #(.ST_W(ST_W)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .wr_stat(wr && idx == IX_STAT), .wr_ien(wr && idx == IX_IEN),
        .wdata(bus_wdata[ST_W-1:0]), .set_vec(set_vec),
        .stat_q(stat_q), .ien_q(ien_q), .irq(irq_out)
    );

    // Read multiplexer; reserved offsets and unused bits return zero
    always_comb begin
        bus_rdata = '0;
        if (in_map) begin
            case (idx)
                IX_HM: begin
                    bus_rdata[HR_LSB +: HR_W] = hms_q.hr;
                    bus_rdata[0 +: MIN_W]     = hms_q.mn;
                end
                IX_SEC:  bus_rdata[0 +: SEC_W] = hms_q.sc;
                IX_AHM: begin
                    bus_rdata[HR_LSB +: HR_W] = al_hms_q.hr;
                    bus_rdata[0 +: MIN_W]     = al_hms_q.mn;
                end
                IX_ASEC: bus_rdata[0 +: SEC_W] = al_hms_q.sc;
                IX_CTRL: bus_rdata[CTRL_RUN]   = run_q;
                IX_STAT: bus_rdata[ST_W-1:0]   = stat_q;
                IX_IEN:  bus_rdata[ST_W-1:0]   = ien_q;
                IX_DAY:  bus_rdata[DAY_W-1:0]  = day_q;
                IX_ADAY: bus_rdata[DAY_W-1:0]  = al_day_q;
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rtc_alarm_checker.sv
// Temporal checks on the real-time clock, attached by bind.
// Assumes it observes the top's internal run, write-strobe and time signals.
module rtc_alarm_checker #(
    parameter int DAY_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_in,
    input logic             run_q,
    input logic             wr_time,
    input logic             wr_sec,
    input logic [5:0]       wdata_sec,
    input logic [5:0]       sec_q,
    input logic [5:0]       min_q,
    input logic [4:0]       hr_q,
    input logic [DAY_W-1:0] day_q,
    input logic             stat_1hz,
    input logic [15:0]      ien_q,
    input logic             irq_out
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !irq_out);

    assert_second_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_in && run_q && !wr_time && sec_q < 6'd59) |=> sec_q == $past(sec_q) + 6'd1);

    assert_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr_time) |=> ($stable(sec_q) && $stable(min_q) && $stable(hr_q) && $stable(day_q)));

    assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_in && run_q && wr_sec) |=> sec_q == $past(wdata_sec));

    assert_onehz_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_in && run_q) |=> stat_1hz);

    assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ien_q != 16'h0);
endmodule

bind rtc_alarm_core rtc_alarm_checker #(.DAY_W(DAY_W)) u_rtc_chk (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .run_q(run_q),
    .wr_time(wr_time), .wr_sec(wr_sec), .wdata_sec(bus_wdata[5:0]),
    .sec_q(hms_q.sc), .min_q(hms_q.mn), .hr_q(hms_q.hr), .day_q(day_q),
    .stat_1hz(stat_q[4]), .ien_q(ien_q), .irq_out(irq_out)
);

// File: tb/test_rtc_alarm_core.sv
`timescale 1ns/1ps
module test_rtc_alarm_core;
    localparam int DAY_W = 9;
    localparam longint DAY_S = 86400;
    localparam longint WRAP_S = DAY_S * (64'd1 << DAY_W);

    logic        clk = 0, rst_n = 0, bus_sel = 0, bus_wr = 0, tick_in = 0;
    logic [5:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        irq_out;
    int          n_run = 0, n_fail = 0;

    rtc_alarm_core #(.DAY_W(DAY_W), .ADDR_W(6)) i_rtc_alarm_core (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_in(tick_in), .irq_out(irq_out)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_sel = 1; bus_wr = 0;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic with_tick);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_sel = 1; bus_wr = 1; tick_in = with_tick;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; tick_in = 0;
    endtask

    task automatic tick();
        @(negedge clk); tick_in = 1;
        @(negedge clk); tick_in = 0;
    endtask

    // Arithmetic model: total seconds -> register images
    task automatic check_time(input string req, input longint t);
        logic [31:0] hm, sc, dy;
        longint r = t % WRAP_S;
        longint tod = r % DAY_S;
        rd(6'h00, hm); rd(6'h04, sc); rd(6'h20, dy);
        check(req, {hm[15:0], sc[7:0], dy[7:0]},
              {8'(tod / 3600), 8'((tod % 3600) / 60), 8'(tod % 60), 8'(r / DAY_S)});
        if (dy[31:8] !== 24'(r / DAY_S >> 8)) check({req, " day high"}, dy, 32'(r / DAY_S));
    endtask

    task automatic load_time(input longint t);
        longint tod = t % DAY_S;
        wr(6'h20, 32'(t / DAY_S), 0);
        wr(6'h04, 32'(tod % 60), 0);
        wr(6'h00, {16'h0, 8'(tod / 3600), 8'((tod % 3600) / 60)}, 0);
    endtask

    initial begin
        #(5.0 * 190000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: all offsets read zero after reset, no interrupt
        for (int a = 0; a < 16; a++) begin
            rd(6'(a * 4), d);
            check($sformatf("R1 reset read offset %0h", a * 4), d, 0);
        end
        check("R1 irq after reset", {31'h0, irq_out}, 0);

        // R2: field layout and unused bits
        wr(6'h00, 32'h0000_1725, 0); rd(6'h00, d); check("R2 hm 23:37", d, 32'h1725);
        wr(6'h00, 32'hFFFF_FFFF, 0); rd(6'h00, d); check("R2 hm all ones", d, 32'h1F3F);
        wr(6'h04, 32'hFFFF_FFFF, 0); rd(6'h04, d); check("R2 sec all ones", d, 32'h3F);
        wr(6'h20, 32'hFFFF_FFFF, 0); rd(6'h20, d); check("R2 day all ones", d, 32'h1FF);
        wr(6'h08, 32'hFFFF_FFFF, 0); rd(6'h08, d); check("R2 alarm hm all ones", d, 32'h1F3F);

        // R5: control readback; halted ticks change nothing
        wr(6'h10, 32'hFFFF_FFFF, 0); rd(6'h10, d); check("R5 ctrl readback", d, 32'h80);
        wr(6'h10, 32'h0, 0); rd(6'h10, d); check("R5 ctrl cleared", d, 32'h0);
        load_time(64'd1000);
        wr(6'h14, 32'hFFFF, 0);
        tick(); tick();
        check_time("R5 halted time", 64'd1000);
        rd(6'h14, d); check("R5 halted status", d, 0);

        // R3 and R4: sweep across minute, hour, day boundaries
        wr(6'h08, 32'h0, 0); wr(6'h24, 32'h1FF, 0); wr(6'h0C, 32'h3F, 0);
        wr(6'h10, 32'h80, 0);
        begin
            longint t0 = 509 * DAY_S + 22 * 3600 + 59 * 60;
            load_time(t0);
            for (int k = 1; k <= 3700; k++) begin
                tick();
                check_time("R3 sweep", t0 + k);
            end
            t0 = 511 * DAY_S + 23 * 3600 + 59 * 60 + 50;
            load_time(t0);
            for (int k = 1; k <= 20; k++) begin
                tick();
                check_time("R4 day wrap", t0 + k);
            end
        end

        // R6: write in the tick cycle wins, other fields untouched
        load_time(64'd3 * DAY_S + 5 * 3600 + 7 * 60 + 20);
        wr(6'h04, 32'd10, 1);
        check_time("R6 write over tick", 64'd3 * DAY_S + 5 * 3600 + 7 * 60 + 10);
        wr(6'h20, 32'd7, 1);
        check_time("R6 day write over tick", 64'd7 * DAY_S + 5 * 3600 + 7 * 60 + 10);

        // R7: one-hertz flag on a running tick
        wr(6'h14, 32'hFFFF, 0); rd(6'h14, d); check("R7 status cleared", d, 0);
        tick(); rd(6'h14, d); check("R7 onehz bit4", d, 32'h10);

        // R8: alarm on full match after a tick
        wr(6'h24, 32'd3, 0); wr(6'h08, 32'h0D14, 0); wr(6'h0C, 32'd5, 0);
        load_time(64'd3 * DAY_S + 13 * 3600 + 20 * 60 + 4);
        wr(6'h14, 32'hFFFF, 0);
        tick(); rd(6'h14, d); check("R8 full match sets bit2", d, 32'h14);
        wr(6'h14, 32'hFFFF, 0); wr(6'h24, 32'd4, 0);
        load_time(64'd3 * DAY_S + 13 * 3600 + 20 * 60 + 4);
        tick(); rd(6'h14, d); check("R8 day mismatch no alarm", d, 32'h10);
        wr(6'h14, 32'hFFFF, 0);
        load_time(64'd4 * DAY_S + 13 * 3600 + 20 * 60 + 5);
        rd(6'h14, d); check("R8 write-made match no alarm", d, 0);
        wr(6'h04, 32'd4, 0);
        tick(); rd(6'h14, d); check("R8 tick into match", d, 32'h14);

        // R9: write-1-to-clear, write-0 holds, set beats clear
        wr(6'h14, 32'h4, 0); rd(6'h14, d); check("R9 clear bit2 only", d, 32'h10);
        wr(6'h14, 32'h0, 0); rd(6'h14, d); check("R9 write zero holds", d, 32'h10);
        wr(6'h14, 32'h10, 1); rd(6'h14, d); check("R9 set wins over clear", d, 32'h10);

        // R10: enable register and interrupt level
        wr(6'h18, 32'hFFFF_0010, 0); rd(6'h18, d); check("R10 enable readback", d, 32'h10);
        @(negedge clk); check("R10 irq on enabled bit", {31'h0, irq_out}, 1);
        wr(6'h18, 32'h4, 0);
        @(negedge clk); check("R10 irq masked", {31'h0, irq_out}, 0);
        wr(6'h14, 32'hFFFF, 0); wr(6'h18, 32'h10, 0);
        @(negedge clk); check("R10 irq no status", {31'h0, irq_out}, 0);

        // R11: reserved offsets
        wr(6'h10, 32'h0, 0);
        load_time(64'd100);
        wr(6'h1C, 32'hFFFF_FFFF, 0);
        rd(6'h1C, d); check("R11 reserved 0x1C", d, 0);
        rd(6'h28, d); check("R11 reserved 0x28", d, 0);
        wr(6'h3C, 32'hFFFF_FFFF, 0);
        rd(6'h3C, d); check("R11 reserved 0x3C", d, 0);
        check_time("R11 time untouched", 64'd100);
        rd(6'h10, d); check("R11 ctrl untouched", d, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule